// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces refresh for a DRAM controller. A 3-bit rate code picks a refresh interval. The intervals are power-of-two multiples of a 15.6 us base tick. A frequency select tells the timer whether the host clock runs at 100 MHz or 66 MHz, so the base tick spans the right number of clocks. When the interval runs out, the timer raises a one-cycle request and sets a pending flag. The pending flag stays set until the controller acknowledges it.

Requests come only while the refresh enable is high and the rate and frequency codes are both valid. Refresh can therefore stay off through memory initialization and be switched on later. A request is never queued behind an unacknowledged one. Instead it raises an overflow flag. All pins are plain control and status signals; no data stream passes through the block.

Top module: `dram_refresh_timer`

## Requirements
- R1: After reset, `req_pulse`, `pending` and `overflow` are all 0.
- R2: With rate code 3'b001, requests come every base tick: `TICK_FAST` clocks when `freq_sel` is 2'b00 (100 MHz) and `TICK_SLOW` clocks when it is 2'b10 (66 MHz).
- R3: Rate codes 3'b010, 3'b011, 3'b100 and 3'b101 set intervals of 2, 4, 8 and 16 base ticks.
- R4: Rate code 3'b000 (off) and the reserved codes 3'b110 and 3'b111 produce no requests.
- R5: No request is produced while `refresh_en` is 0.
- R6: The reserved frequency codes 2'b01 and 2'b11 produce no requests.
- R7: A change in `rate_code`, `refresh_en` or `freq_sel` restarts the interval. The first request then appears N clocks after the clock edge that sees the change, where N is the interval in clocks, and every later request follows N clocks after the previous one.
- R8: `req_pulse` is high for exactly one cycle per request. `pending` rises together with it and stays high until an acknowledge.
- R9: `ack` high at a clock edge clears `pending` and `overflow`. If a request fires at that same edge, the request wins and `pending` stays set.
- R10: A request that fires while `pending` is already set sets `overflow`. `pending` stays high and nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_code | input | 3 | Refresh interval select |
| refresh_en | input | 1 | Enables refresh requests |
| freq_sel | input | 2 | Host clock select: 2'b00 = 100 MHz, 2'b10 = 66 MHz |
| ack | input | 1 | Controller has taken the pending request |
| req_pulse | output | 1 | One-cycle refresh request |
| pending | output | 1 | A request is waiting for acknowledge |
| overflow | output | 1 | A request fired while the previous one was still pending |

## Verification
A wrong count or wrong interval limit shows up as a `req_pulse` edge that lands early or late. The bench sees this at the first request after a restart, at most 16 base ticks after the configuration is applied. A configuration register that misses a change shows up as a request that keeps the old phase, which the bench detects at the next expected edge. A fault in the pending or overflow state is visible in the same cycle, because the bench compares both flags against a behavioural model on every clock.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;
  localparam logic [1:0] FREQ_100 = 2'b00;
  localparam logic [1:0] FREQ_66  = 2'b10;
  localparam logic [2:0] RATE_MAX = 3'd5;
  localparam int         MULT_W   = int'(RATE_MAX) - 1;

  typedef struct packed {
    logic [2:0] rate;
    logic       en;
    logic [1:0] freq;
  } rfsh_cfg_t;

  function automatic logic rate_ok(input logic [2:0] r);
    return (r != 3'd0) && (r <= RATE_MAX);
  endfunction

  function automatic logic freq_ok(input logic [1:0] f);
    return (f == FREQ_100) || (f == FREQ_66);
  endfunction
endpackage

// File: rtl/refresh_cfg_track.sv
module refresh_cfg_track
  import refresh_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rfsh_cfg_t cfg_in,
  output logic      restart,
  output logic      active,
  output logic [2:0] rate_q,
  output logic      fast
);
  rfsh_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_in;
  end

  assign restart = (cfg_in != cfg_q);
  assign active  = cfg_q.en && rate_ok(cfg_q.rate) && freq_ok(cfg_q.freq);
  assign rate_q  = cfg_q.rate;
  assign fast    = (cfg_q.freq == FREQ_100);
endmodule

// File: rtl/refresh_interval_count.sv
module refresh_interval_count
  import refresh_timer_pkg::*;
#(
  parameter int TICK_FAST = 1560,
  parameter int TICK_SLOW = 1040
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       active,
  input  logic [2:0] rate,
  input  logic       fast,
  output logic       fire
);
  localparam int TICK_MAX = (TICK_FAST > TICK_SLOW) ? TICK_FAST : TICK_SLOW;
  localparam int TICK_W   = (TICK_MAX > 2) ? $clog2(TICK_MAX) : 1;

  logic [TICK_W-1:0] tick_cnt, tick_lim;
  logic [MULT_W-1:0] mult_cnt, mult_lim;
  logic              tick_end;

  assign tick_lim = fast ? TICK_W'(TICK_FAST - 1) : TICK_W'(TICK_SLOW - 1);
  assign mult_lim = MULT_W'((5'd1 << (rate - 3'd1)) - 5'd1);
  assign tick_end = (tick_cnt == tick_lim);
  assign fire     = active && !restart && tick_end && (mult_cnt == mult_lim);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !active) begin
      tick_cnt <= '0;
      mult_cnt <= '0;
    end else if (tick_end) begin
      tick_cnt <= '0;
      mult_cnt <= (mult_cnt == mult_lim) ? '0 : mult_cnt + 1'b1;
    end else begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_req_track.sv
module refresh_req_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ack,
  output logic req_pulse,
  output logic pending,
  output logic overflow
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_pulse <= 1'b0;
      pending   <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      req_pulse <= fire;
      if (fire) begin
        pending <= 1'b1;
        if (pending) overflow <= 1'b1;
      end else if (ack) begin
        pending  <= 1'b0;
        overflow <= 1'b0;
      end
    end
  end

  p_pulse_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |=> !req_pulse);
  p_pend_with_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |-> pending);
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !fire) |=> (!pending && !overflow));
  p_ovf_on_repeat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pulse && $past(pending)) |-> overflow);
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer
  import refresh_timer_pkg::*;
#(
  parameter int TICK_FAST = 1560,
  parameter int TICK_SLOW = 1040
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_code,
  input  logic       refresh_en,
  input  logic [1:0] freq_sel,
  input  logic       ack,
  output logic       req_pulse,
  output logic       pending,
  output logic       overflow
);
  rfsh_cfg_t  cfg_in;
  logic       restart, active, fast, fire;
  logic [2:0] rate_q;

  assign cfg_in = '{rate: rate_code, en: refresh_en, freq: freq_sel};

  refresh_cfg_track u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in),
    .restart(restart), .active(active), .rate_q(rate_q), .fast(fast)
  );

  refresh_interval_count #(.TICK_FAST(TICK_FAST), .TICK_SLOW(TICK_SLOW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .active(active),
    .rate(rate_q), .fast(fast), .fire(fire)
  );

  refresh_req_track u_req (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ack(ack),
    .req_pulse(req_pulse), .pending(pending), .overflow(overflow)
  );

  p_no_req_bad_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == 3'd0 || rate_code > 3'd5) |=> !req_pulse);
  p_no_req_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_en |=> !req_pulse);
  p_no_req_bad_freq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_sel == 2'b01 || freq_sel == 2'b11) |=> !req_pulse);
endmodule

// File: tb/dram_refresh_timer_tb.sv
module dram_refresh_timer_tb;
  localparam int TF = 24;
  localparam int TS = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] rate_code = 3'd0;
  logic refresh_en = 1'b0;
  logic [1:0] freq_sel = 2'b00;
  logic ack = 1'b0;
  logic req_pulse, pending, overflow;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_refresh_timer #(.TICK_FAST(TF), .TICK_SLOW(TS)) u_dut (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .refresh_en(refresh_en),
    .freq_sel(freq_sel), .ack(ack),
    .req_pulse(req_pulse), .pending(pending), .overflow(overflow)
  );

  function automatic int interval(input logic [2:0] r, input logic [1:0] f);
    int base;
    base = (f == 2'b00) ? TF : TS;
    return base << (r - 1);
  endfunction

  function automatic bit live(input logic [2:0] r, input logic e, input logic [1:0] f);
    return e && r >= 1 && r <= 5 && (f == 2'b00 || f == 2'b10);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [5:0] m_cfg = '0;
  int  m_cnt = 0;
  bit  m_req = 0, m_pend = 0, m_ovf = 0;

  always @(posedge clk) begin
    bit fire;
    fire = 0;
    if (!rst_n) begin
      m_cfg = '0; m_cnt = 0; m_req = 0; m_pend = 0; m_ovf = 0;
    end else begin
      if ({rate_code, refresh_en, freq_sel} != m_cfg) begin
        m_cfg = {rate_code, refresh_en, freq_sel};
        m_cnt = 0;
      end else if (live(m_cfg[5:3], m_cfg[2], m_cfg[1:0])) begin
        m_cnt++;
        if (m_cnt == interval(m_cfg[5:3], m_cfg[1:0])) begin
          fire = 1; m_cnt = 0;
        end
      end
      m_req = fire;
      if (fire) begin
        m_ovf = m_ovf | m_pend; m_pend = 1;
      end else if (ack) begin
        m_pend = 0; m_ovf = 0;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk(req_pulse === m_req, "R7 req_pulse vs model", req_pulse, m_req);
      chk(pending === m_pend, "R8 pending vs model", pending, m_pend);
      chk(overflow === m_ovf, "R10 overflow vs model", overflow, m_ovf);
    end
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Apply a fresh config after a disabled gap; report the step of the first
  // request (0 if none) and the number of requests within the window.
  task automatic measure(input logic [2:0] r, input logic e, input logic [1:0] f,
                         input int limit, output int first, output int pulses);
    @(negedge clk); refresh_en = 0; rate_code = 0; freq_sel = 2'b00; ack = 1;
    @(negedge clk); @(negedge clk); ack = 0;
    rate_code = r; refresh_en = e; freq_sel = f;
    first = 0; pulses = 0;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk); #1;
      if (req_pulse) begin
        pulses++;
        if (first == 0) first = k;
      end
    end
  endtask

  initial begin
    int first, pulses, hits;
    repeat (3) @(negedge clk);
    chk(req_pulse === 0 && pending === 0 && overflow === 0, "R1 reset outputs",
        {req_pulse, pending, overflow}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(req_pulse === 0 && pending === 0 && overflow === 0, "R1 after release",
        {req_pulse, pending, overflow}, 0);

    // R2 base tick at both clock selects; R8/R10 with no ack
    measure(3'd1, 1, 2'b00, 3*TF + 2, first, pulses);
    chk(first == TF + 1, "R2 first request at 100 MHz", first, TF + 1);
    chk(pulses == 3, "R8 one pulse per interval", pulses, 3);
    #1 chk(pending === 1, "R8 pending held without ack", pending, 1);
    chk(overflow === 1, "R10 overflow after repeat", overflow, 1);
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
    chk(pending === 0 && overflow === 0, "R9 ack clears flags",
        {pending, overflow}, 0);

    measure(3'd1, 1, 2'b10, TS + 2, first, pulses);
    chk(first == TS + 1, "R2 first request at 66 MHz", first, TS + 1);

    // R3 longer intervals
    measure(3'd2, 1, 2'b10, interval(3'd2, 2'b10) + 2, first, pulses);
    chk(first == interval(3'd2, 2'b10) + 1, "R3 rate 2", first, interval(3'd2, 2'b10) + 1);
    measure(3'd3, 1, 2'b00, interval(3'd3, 2'b00) + 2, first, pulses);
    chk(first == interval(3'd3, 2'b00) + 1, "R3 rate 3", first, interval(3'd3, 2'b00) + 1);
    measure(3'd4, 1, 2'b10, interval(3'd4, 2'b10) + 2, first, pulses);
    chk(first == interval(3'd4, 2'b10) + 1, "R3 rate 4", first, interval(3'd4, 2'b10) + 1);
    measure(3'd5, 1, 2'b00, 2*interval(3'd5, 2'b00) + 2, first, pulses);
    chk(first == interval(3'd5, 2'b00) + 1, "R3 rate 5", first, interval(3'd5, 2'b00) + 1);
    chk(pulses == 2, "R3 rate 5 repeats", pulses, 2);

    // R4 off and reserved rates
    measure(3'd0, 1, 2'b00, 400, first, pulses);
    chk(pulses == 0, "R4 rate 0 silent", pulses, 0);
    measure(3'd6, 1, 2'b00, 400, first, pulses);
    chk(pulses == 0, "R4 rate 6 silent", pulses, 0);
    measure(3'd7, 1, 2'b10, 400, first, pulses);
    chk(pulses == 0, "R4 rate 7 silent", pulses, 0);
    #1 chk(pending === 0, "R4 nothing pending", pending, 0);

    // R5 enable off
    measure(3'd1, 0, 2'b00, 200, first, pulses);
    chk(pulses == 0, "R5 disabled silent", pulses, 0);

    // R6 reserved frequency codes
    measure(3'd1, 1, 2'b01, 200, first, pulses);
    chk(pulses == 0, "R6 freq 01 silent", pulses, 0);
    measure(3'd1, 1, 2'b11, 200, first, pulses);
    chk(pulses == 0, "R6 freq 11 silent", pulses, 0);

    // R7 rate change mid-interval restarts the count
    @(negedge clk); ack = 1; rate_code = 3'd2; refresh_en = 1; freq_sel = 2'b00;
    hits = 0;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #1; if (req_pulse) hits++;
    end
    chk(hits == 0, "R7 no request before change", hits, 0);
    @(negedge clk); ack = 0; rate_code = 3'd1;
    first = 0;
    for (int k = 1; k <= TF + 2; k++) begin
      @(posedge clk); #1; if (req_pulse && first == 0) first = k;
    end
    chk(first == TF + 1, "R7 restart after rate change", first, TF + 1);

    // R9 ack held high: a request at the same edge wins
    @(negedge clk); ack = 1;
    hits = 0;
    for (int k = 0; k < 3*TF; k++) begin
      @(posedge clk); #1;
      if (req_pulse) begin
        hits++;
        chk(pending === 1 && overflow === 0, "R9 request beats ack",
            {pending, overflow}, 2);
      end
    end
    chk(hits >= 2, "R9 requests seen while ack held", hits, 2);
    @(negedge clk); ack = 0; refresh_en = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule